// File: doc/BRIEF.md
# Timer Compare Output Unit

This block watches a free-running timer value and compares it, every cycle, against a compare value held in byte-wide registers. When the two are fully equal the block raises a sticky interrupt flag and, depending on the selected mode, sets, clears or toggles an output latch. The latch drives a shared pin. While a compare mode is active the block owns the pin: the output enable is forced on and the pin value is the latch. While no compare mode is active, the pin value and enable come from the ordinary port logic.

Software programs the block through a small byte register interface. Address 0 holds the 4-bit mode field. Addresses 1 and 2 hold the low and high compare bytes. A write to address 3 clears the interrupt flag. The same addresses can be read back combinationally. A mode write that changes the mode also puts the latch into a known starting state. This lets software switch between the set and clear behaviours without an unexpected pin edge. The recommended way to switch is to write mode 0000 first.

Top module: `timer_compare_unit`

## Requirements
- R1: After reset, mode, compare value, latch and flag are all 0. The pin value equals `port_data` and the pin enable equals `port_oe`.
- R2: A write to address 0 stores `wr_data[3:0]` as the mode. A write to address 1 stores the low compare byte and a write to address 2 stores the high compare byte. Reads of addresses 0, 1 and 2 return {4'b0, mode}, the low byte and the high byte. A read of address 3 returns {7'b0, flag}.
- R3: A match needs the full 16-bit timer value to equal the 16-bit compare value. Equality of one byte alone does nothing.
- R4: Mode 4'b1000 (set) drives the latch to 1 at the clock edge that sees a match. A write that changes the mode to 1000 forces the latch to 0.
- R5: Mode 4'b1001 (clear) drives the latch to 0 at a match. A write that changes the mode to 1001 forces the latch to 1.
- R6: Mode 4'b0010 (toggle) inverts the latch at each match. Entering toggle mode leaves the latch unchanged.
- R7: In any of the three active modes, every match sets the flag at the same edge that updates the latch.
- R8: A match is acted on once per arrival at the matching value. A timer that stays at the compare value does not retrigger the latch action or the flag.
- R9: The flag stays set until a write to address 3 clears it. If a match sets the flag in the same cycle as that write, the flag stays set.
- R10: Any mode other than 1000, 1001 or 0010 (0000 included) is off. In an off mode the latch is 0, the pin follows `port_data` and `port_oe`, and a match does not set the flag.
- R11: If a mode-changing write arrives in the same cycle as a match, the entry value of the new mode wins over the match action. The flag still follows the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| timer_val | input | 16 | Current timer count, high byte in bits 15:8 |
| port_data | input | 1 | Port data latch value for the shared pin |
| port_oe | input | 1 | Port output enable for the shared pin |
| pin_out | output | 1 | Value driven on the shared pin |
| pin_oe | output | 1 | Output enable of the shared pin |
| irq_flag | output | 1 | Sticky compare interrupt flag |

## Verification
Every state change lands at the first rising edge after its cause. A match, a register write or a flag clear presented before edge N is visible on `pin_out`, `irq_flag` and `rd_data` just after edge N. The bench drives inputs on the falling edge and samples 1 ns after the rising edge. Its reference model is advanced once per rising edge in the same order, so each expected value belongs to the cycle in which the design must show it. For the hold case (R8) the timer is parked on the compare value for several cycles. The bench then checks that the flag and pin stay unchanged across that whole window.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_OFF = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_SET = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_CLR = 4'b1001;
    localparam logic [MODE_W-1:0] MODE_TGL = 4'b0010;

    function automatic logic is_active(input logic [MODE_W-1:0] m);
        return (m == MODE_SET) || (m == MODE_CLR) || (m == MODE_TGL);
    endfunction

    // Latch value forced when a mode is entered; toggle keeps the old value.
    function automatic logic entry_value(input logic [MODE_W-1:0] m, input logic cur);
        case (m)
            MODE_SET: return 1'b0;
            MODE_CLR: return 1'b1;
            MODE_TGL: return cur;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tc_regs.sv
module tc_regs #(
    parameter int TMR_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     flag,
    output logic [tc_pkg::MODE_W-1:0] mode_q_o,
    output logic [TMR_W-1:0]         cmp_q_o,
    output logic                     mode_chg,
    output logic [tc_pkg::MODE_W-1:0] mode_nx,
    output logic                     clr_req,
    output logic [7:0]               rd_data
);
    localparam int NB       = TMR_W / 8;
    localparam int MW       = tc_pkg::MODE_W;
    localparam int CLR_ADDR = NB + 1;

    typedef struct packed {
        logic [MW-1:0]    mode;
        logic [TMR_W-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;
    logic [NB-1:0] byte_wr;
    logic [NB-1:0] byte_rd;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign byte_wr[b] = wr_en && (wr_addr == ADDR_W'(b + 1));
            assign byte_rd[b] = (rd_addr == ADDR_W'(b + 1));
        end
    endgenerate

    assign mode_nx  = wr_data[MW-1:0];
    assign mode_chg = wr_en && (wr_addr == '0) && (wr_data[MW-1:0] != r_q.mode);
    assign clr_req  = wr_en && (wr_addr == ADDR_W'(CLR_ADDR));

    always_comb begin
        r_d = r_q;
        if (wr_en && (wr_addr == '0)) r_d.mode = wr_data[MW-1:0];
        for (int b = 0; b < NB; b++) begin
            if (byte_wr[b]) r_d.cmp[b*8 +: 8] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = 8'(r_q.mode);
        else if (rd_addr == ADDR_W'(CLR_ADDR)) rd_data = {7'b0, flag};
        for (int b = 0; b < NB; b++) begin
            if (byte_rd[b]) rd_data = r_q.cmp[b*8 +: 8];
        end
    end

    assign mode_q_o = r_q.mode;
    assign cmp_q_o  = r_q.cmp;

    // R2
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (mode_q_o == $past(wr_data[MW-1:0])));
endmodule

// File: rtl/tc_match.sv
module tc_match #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] timer_val,
    input  logic [TMR_W-1:0] cmp_val,
    output logic             evt
);
    typedef struct packed {
        logic prev;
    } mst_t;

    mst_t m_d, m_q;
    logic hit;

    always_comb begin
        hit      = (timer_val == cmp_val);
        evt      = hit && !m_q.prev;
        m_d.prev = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    // R8
    single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    // R3
    evt_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (timer_val == cmp_val));
endmodule

// File: rtl/tc_action.sv
module tc_action (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [tc_pkg::MODE_W-1:0] mode_q,
    input  logic                      mode_chg,
    input  logic [tc_pkg::MODE_W-1:0] mode_nx,
    input  logic                      evt,
    input  logic                      clr_req,
    output logic                      latch_o,
    output logic                      flag_o
);
    import tc_pkg::*;

    typedef struct packed {
        logic latch;
        logic flag;
    } act_t;

    act_t a_d, a_q;
    logic fire;

    always_comb begin
        a_d  = a_q;
        fire = evt && is_active(mode_q);
        if (mode_chg) begin
            a_d.latch = entry_value(mode_nx, a_q.latch);
        end else if (fire) begin
            case (mode_q)
                MODE_SET: a_d.latch = 1'b1;
                MODE_CLR: a_d.latch = 1'b0;
                MODE_TGL: a_d.latch = !a_q.latch;
                default:  a_d.latch = 1'b0;
            endcase
        end
        if (fire)         a_d.flag = 1'b1;
        else if (clr_req) a_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign latch_o = a_q.latch;
    assign flag_o  = a_q.flag;

    // R4
    set_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_q == MODE_SET && !mode_chg) |=> latch_o);
    // R5
    clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_q == MODE_CLR && !mode_chg) |=> !latch_o);
    // R6
    tgl_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_q == MODE_TGL && !mode_chg) |=> (latch_o != $past(latch_o)));
    // R11
    set_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && mode_nx == MODE_SET) |=> !latch_o);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && is_active(mode_q)) |=> flag_o);
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(clr_req));
endmodule

// File: rtl/timer_compare_unit.sv
module timer_compare_unit #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic [TMR_W-1:0] timer_val,
    input  logic             port_data,
    input  logic             port_oe,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq_flag
);
    localparam int ADDR_W = 2;
    localparam int MW     = tc_pkg::MODE_W;

    logic [MW-1:0]    mode_q;
    logic [MW-1:0]    mode_nx;
    logic [TMR_W-1:0] cmp_q;
    logic             mode_chg;
    logic             clr_req;
    logic             evt;
    logic             latch_q;
    logic             flag_q;
    logic             owned;

    tc_regs #(.TMR_W(TMR_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .flag     (flag_q),
        .mode_q_o (mode_q),
        .cmp_q_o  (cmp_q),
        .mode_chg (mode_chg),
        .mode_nx  (mode_nx),
        .clr_req  (clr_req),
        .rd_data  (rd_data)
    );

    tc_match #(.TMR_W(TMR_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_val (timer_val),
        .cmp_val   (cmp_q),
        .evt       (evt)
    );

    tc_action u_action (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q   (mode_q),
        .mode_chg (mode_chg),
        .mode_nx  (mode_nx),
        .evt      (evt),
        .clr_req  (clr_req),
        .latch_o  (latch_q),
        .flag_o   (flag_q)
    );

    assign owned    = tc_pkg::is_active(mode_q);
    assign pin_out  = owned ? latch_q : port_data;
    assign pin_oe   = owned ? 1'b1    : port_oe;
    assign irq_flag = flag_q;

    // R10
    off_latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_pkg::is_active(mode_q) |-> !latch_q);
    // R10
    off_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_pkg::is_active(mode_q) && !irq_flag) |=> !irq_flag);
endmodule

// File: tb/timer_compare_unit_tb.sv
module timer_compare_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] timer_val = '0;
    logic        port_data = 1'b1;
    logic        port_oe = 1'b0;
    logic        pin_out, pin_oe, irq_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [3:0]  m_mode = '0;
    logic [15:0] m_cmp = '0;
    logic        m_latch = 0, m_flag = 0, m_prev = 0;

    always #2.5 clk = ~clk;

    timer_compare_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .timer_val(timer_val),
        .port_data(port_data), .port_oe(port_oe), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_flag(irq_flag)
    );

    function automatic bit act(input logic [3:0] m);
        return m == 4'b1000 || m == 4'b1001 || m == 4'b0010;
    endfunction

    function automatic logic exp_pin();
        return act(m_mode) ? m_latch : port_data;
    endfunction

    function automatic logic exp_oe();
        return act(m_mode) ? 1'b1 : port_oe;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_mode};
            2'd1: return m_cmp[7:0];
            2'd2: return m_cmp[15:8];
            default: return {7'b0, m_flag};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] actv, input logic [15:0] expv);
        checks++;
        if (actv !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, actv, expv, $time);
        end
    endtask

    // model update at a rising edge, from the requirements
    task automatic model_edge();
        logic hit, ev, fire;
        hit = (timer_val == m_cmp);
        ev  = hit && !m_prev;
        m_prev = hit;
        fire = ev && act(m_mode);
        if (wr_en && wr_addr == 2'd0 && wr_data[3:0] != m_mode) begin
            case (wr_data[3:0])
                4'b1000: m_latch = 0;
                4'b1001: m_latch = 1;
                4'b0010: m_latch = m_latch;
                default: m_latch = 0;
            endcase
        end else if (fire) begin
            if (m_mode == 4'b1000) m_latch = 1;
            else if (m_mode == 4'b1001) m_latch = 0;
            else m_latch = !m_latch;
        end
        if (fire) m_flag = 1;
        else if (wr_en && wr_addr == 2'd3) m_flag = 0;
        if (wr_en && wr_addr == 2'd0) m_mode = wr_data[3:0];
        if (wr_en && wr_addr == 2'd1) m_cmp[7:0] = wr_data;
        if (wr_en && wr_addr == 2'd2) m_cmp[15:8] = wr_data;
    endtask

    task automatic cyc(input bit we, input logic [1:0] a, input logic [7:0] d,
                       input logic [15:0] t, input logic [1:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; timer_val = t; rd_addr = ra;
        @(posedge clk);
        model_edge();
        #1;
        chk("R4/R5/R6/R10 pin_out", 16'(pin_out), 16'(exp_pin()));
        chk("R10 pin_oe", 16'(pin_oe), 16'(exp_oe()));
        chk("R7/R8/R9 irq_flag", 16'(irq_flag), 16'(m_flag));
        chk("R2 rd_data", 16'(rd_data), 16'(exp_rd(ra)));
    endtask

    task automatic idle(input logic [15:0] t);
        cyc(0, 2'd0, 8'd0, t, 2'd3);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] t;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 pin_out", 16'(pin_out), 16'd1);
        chk("R1 pin_oe", 16'(pin_oe), 16'd0);
        chk("R1 irq_flag", 16'(irq_flag), 16'd0);
        chk("R1 rd_data", 16'(rd_data), 16'd0);
        @(negedge clk); rst_n = 1;

        // R2 program compare 0x1234, set mode
        cyc(1, 2'd1, 8'h34, 16'h0, 2'd1);
        cyc(1, 2'd2, 8'h12, 16'h0, 2'd2);
        chk("R2 high byte", 16'(rd_data), 16'h12);
        cyc(1, 2'd0, 8'hF8, 16'h0, 2'd0);
        chk("R2 mode readback", 16'(rd_data), 16'h08);
        chk("R4 entry low", 16'(pin_out), 16'd0);
        // R3 low byte equal only
        idle(16'h5534);
        chk("R3 partial no flag", 16'(irq_flag), 16'd0);
        idle(16'h1235);
        idle(16'h1234);
        chk("R4 set on match", 16'(pin_out), 16'd1);
        chk("R7 flag on match", 16'(irq_flag), 16'd1);
        // R8/R9 held value: clear, no retrigger
        cyc(1, 2'd3, 8'h00, 16'h1234, 2'd3);
        idle(16'h1234); idle(16'h1234);
        chk("R8 held no retrigger", 16'(irq_flag), 16'd0);
        chk("R9 cleared", 16'(irq_flag), 16'd0);
        // R5 clear mode
        cyc(1, 2'd0, 8'h09, 16'h1234, 2'd0);
        chk("R5 entry high", 16'(pin_out), 16'd1);
        idle(16'h1000); idle(16'h1234);
        chk("R5 clear on match", 16'(pin_out), 16'd0);
        // R9 set wins over clear
        idle(16'h0); cyc(1, 2'd0, 8'h08, 16'h1234, 2'd3);
        chk("R11 entry wins", 16'(pin_out), 16'd0);
        chk("R11 flag by old mode", 16'(irq_flag), 16'd1);
        idle(16'h0);
        cyc(1, 2'd3, 8'h00, 16'h1234, 2'd3);
        chk("R9 set beats clear", 16'(irq_flag), 16'd1);
        // R6 toggle
        cyc(1, 2'd0, 8'h02, 16'h0, 2'd0);
        chk("R6 entry keeps", 16'(pin_out), 16'd1);
        idle(16'h1234);
        chk("R6 toggle 1", 16'(pin_out), 16'd0);
        idle(16'h1); idle(16'h1234);
        chk("R6 toggle 2", 16'(pin_out), 16'd1);
        // R10 off modes
        cyc(1, 2'd3, 8'h0, 16'h0, 2'd3);
        cyc(1, 2'd0, 8'h05, 16'h0, 2'd0);
        port_data = 0; port_oe = 1;
        idle(16'h1234);
        chk("R10 pin port", 16'(pin_out), 16'd0);
        chk("R10 oe port", 16'(pin_oe), 16'd1);
        chk("R10 no flag", 16'(irq_flag), 16'd0);
        cyc(1, 2'd0, 8'h00, 16'h0, 2'd0);
        idle(16'h1234);
        chk("R10 off no flag", 16'(irq_flag), 16'd0);

        // constrained random phase
        t = 16'h1200;
        for (int i = 0; i < 3000; i++) begin
            bit we; logic [1:0] a; logic [7:0] d; int r;
            r = int'($urandom_range(0, 99));
            if (r < 3) t = m_cmp - 16'd2;
            else if (r < 10) t = t;
            else t = t + 16'd1;
            we = ($urandom_range(0, 15) == 0);
            a  = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
                0: d = 8'h08; 1: d = 8'h09; 2: d = 8'h02; 3: d = 8'h00;
                default: d = 8'($urandom_range(0, 255));
            endcase
            if (a != 2'd0 && $urandom_range(0, 1) == 1) d = 8'($urandom_range(0, 3));
            port_data = 1'($urandom_range(0, 1));
            port_oe   = 1'($urandom_range(0, 1));
            cyc(we, a, d, t, 2'($urandom_range(0, 3)));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule